// File: doc/BRIEF.md
# Bus-Master DMA Sequencer

This block drives the local-side master port of a fixed 32-bit PCI master/target core that never inserts wait states. Software programs a small register file through a simple register bus: a read channel (address, length) and a write channel (address, length) plus one control word and one status word. When a channel is started, the sequencer arbitrates between pending channels, raises the burst request, and presents a latched PCI command and byte-enable value. The core answers with one data-phase strobe per word.

On every acknowledged data phase the active address advances by four bytes and the channel's word count drops by one. A channel is cut into bursts no longer than the programmed burst length, where a length of zero means one unlimited burst. During reads, the sequencer warns the core when two words and then one word of the burst remain. The request is held until the cycle after the last data phase and is low from the second cycle after it. Write bursts are closed by the core's single-cycle write-done pulse. When a channel's count reaches zero, its done bit is set and, if enabled, the interrupt is raised.

The sequencer is a five-state machine:
- **IDLE**: grants a pending channel and goes to BURST.
- **BURST**: the request is high and data phases are counted; the last one moves to HOLD.
- **HOLD**: the request stays high for one cycle. Reads go to CLOSE; writes go to WAIT_DONE.
- **WAIT_DONE**: the request is low until the write-done pulse, which moves to CLOSE.
- **CLOSE**: the request is low. The finished channel is retired if its count is zero, and the machine returns to IDLE.

Top module: `dma_seq`

## Requirements
- R1: Registers are selected by `reg_idx` and all reset to zero. The indices are:
  - 0: read address.
  - 1: write address.
  - 2: lengths in words, read length in bits 15:0 and write length in bits 31:16.
  - 3: control. Bit 0 starts a read, bit 1 starts a write, bit 2 enables the interrupt, and bit 3 makes writes win arbitration. Bit 4 selects per-word byte enables and bit 5 selects read termination on empty. Bits 15:8 hold the burst length, bits 19:16 the active-low byte enables, bits 23:20 the read command and bits 27:24 the write command.
  - 4: status. Bit 0 is read done and bit 1 is write done.
  `reg_rdata` returns the selected register combinationally; indices 5 to 7 read as zero.
- R2: A start bit is set only when three things hold: 1 is written to it, the channel length is non-zero, and the command written with it is of the right class. Read-class codes are 0x0, 0x2, 0x6, 0xA, 0xC and 0xE, and every other code is write-class. A refused start leaves the bit at 0 and raises no request. Hardware clears the start bit when the channel completes.
- R3: When both channels are pending in IDLE, the read is granted if control bit 3 is 0 and the write is granted if it is 1.
- R4: Each burst moves the smaller of the remaining length and the burst length. A burst length of 0 moves the whole remaining length in one burst.
- R5: `mreq` is high from the grant through the cycle after the last data phase of a burst, and low in the second cycle after it.
- R6: `mcmd` and `m_be_n` are loaded from the granted channel's command field and from control bits 19:16 at grant, and they do not change while `mreq` is high.
- R7: Each data phase adds 4 to the active channel's address register and subtracts 1 from its length.
- R8: During a read burst, `m_two_left` is high while the next data phase is the second-to-last of the burst, and `m_one_left` is high while it is the last. A one-word burst never shows `m_two_left`. Both flags stay low when control bits 4 and 5 are both set.
- R9: After each write burst, no further request is raised and the channel is not retired until `core_wr_done` pulses.
- R10: A completed channel sets its status done bit. Writing 1 to a status bit clears it. `irq` is high exactly when control bit 2 is set and a done bit is set.
- R11: `m_be_per_word` and `m_rd_term_empty` carry control bits 4 and 5 as latched at grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mreq | output | 1 | Burst request to the core |
| mcmd | output | 4 | PCI command for the burst |
| m_rd_addr | output | 32 | Current read address |
| m_wr_addr | output | 32 | Current write address |
| m_be_n | output | 4 | Constant active-low byte enables |
| m_be_per_word | output | 1 | Per-word byte-enable select |
| m_rd_term_empty | output | 1 | Read termination on core FIFO empty |
| m_one_left | output | 1 | One read phase remains in the burst |
| m_two_left | output | 1 | Two read phases remain in the burst |
| core_wr_ack | input | 1 | Write data phase accepted by the core |
| core_rd_valid | input | 1 | Read data phase delivered by the core |
| core_wr_done | input | 1 | Single-cycle write burst completion |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume the core model honours the request: it strobes a data phase only while `mreq` is high in a burst, it never exceeds the granted burst size, and it does not strobe during the hold cycle. They also assume software does not rewrite an address register in the cycle that address steps. The bench core serves exactly the number of phases it computes from the programmed length and burst length. It stops its strobes on the last phase, and it writes registers only while both channels are idle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int REG_W  = 32;
    localparam int LEN_W  = REG_W / 2;
    localparam int BLEN_W = 8;
    localparam int CMD_W  = 4;
    localparam int BE_W   = 4;
    localparam int IDX_W  = 3;
    localparam int STEP   = 4;

    // control word bit positions
    localparam int C_GO_RD   = 0;
    localparam int C_GO_WR   = 1;
    localparam int C_IRQ_EN  = 2;
    localparam int C_PREF_WR = 3;
    localparam int C_BE_WORD = 4;
    localparam int C_TERM    = 5;
    localparam int C_BLEN_LO = 8;
    localparam int C_BE_LO   = 16;
    localparam int C_RCMD_LO = 20;
    localparam int C_WCMD_LO = 24;

    localparam logic [IDX_W-1:0] IDX_RADDR = 3'd0;
    localparam logic [IDX_W-1:0] IDX_WADDR = 3'd1;
    localparam logic [IDX_W-1:0] IDX_LEN   = 3'd2;
    localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_STAT  = 3'd4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BURST,
        S_HOLD,
        S_WAIT_DONE,
        S_CLOSE
    } seq_state_t;

    function automatic logic is_read_cmd(input logic [CMD_W-1:0] c);
        case (c)
            4'h0, 4'h2, 4'h6, 4'hA, 4'hC, 4'hE: return 1'b1;
            default:                            return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              step_rd,
    input  logic              step_wr,
    input  logic              fin_rd,
    input  logic              fin_wr,
    output logic [REG_W-1:0]  rd_addr,
    output logic [REG_W-1:0]  wr_addr,
    output logic [LEN_W-1:0]  rd_len,
    output logic [LEN_W-1:0]  wr_len,
    output logic              go_rd,
    output logic              go_wr,
    output logic              prefer_wr,
    output logic              be_word,
    output logic              term_empty,
    output logic [BLEN_W-1:0] blen,
    output logic [BE_W-1:0]   be_n,
    output logic [CMD_W-1:0]  rd_cmd,
    output logic [CMD_W-1:0]  wr_cmd,
    output logic              irq
);

    logic [REG_W-1:2] ctrl_q;
    logic             rd_done, wr_done;
    logic             ctrl_wr, stat_wr;

    assign ctrl_wr = we && (idx == IDX_CTRL);
    assign stat_wr = we && (idx == IDX_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr <= '0;
            wr_addr <= '0;
            rd_len  <= '0;
            wr_len  <= '0;
            ctrl_q  <= '0;
            go_rd   <= 1'b0;
            go_wr   <= 1'b0;
            rd_done <= 1'b0;
            wr_done <= 1'b0;
        end else begin
            if (we && idx == IDX_RADDR)
                rd_addr <= wdata;
            else if (step_rd)
                rd_addr <= rd_addr + REG_W'(STEP);

            if (we && idx == IDX_WADDR)
                wr_addr <= wdata;
            else if (step_wr)
                wr_addr <= wr_addr + REG_W'(STEP);

            if (we && idx == IDX_LEN) begin
                rd_len <= wdata[LEN_W-1:0];
                wr_len <= wdata[REG_W-1:LEN_W];
            end else begin
                if (step_rd) rd_len <= rd_len - 1'b1;
                if (step_wr) wr_len <= wr_len - 1'b1;
            end

            if (ctrl_wr) begin
                ctrl_q <= wdata[REG_W-1:2];
                if (wdata[C_GO_RD] && rd_len != '0 &&
                    is_read_cmd(wdata[C_RCMD_LO +: CMD_W]))
                    go_rd <= 1'b1;
                if (wdata[C_GO_WR] && wr_len != '0 &&
                    !is_read_cmd(wdata[C_WCMD_LO +: CMD_W]))
                    go_wr <= 1'b1;
            end
            if (fin_rd) go_rd <= 1'b0;
            if (fin_wr) go_wr <= 1'b0;

            if (fin_rd)                  rd_done <= 1'b1;
            else if (stat_wr && wdata[0]) rd_done <= 1'b0;
            if (fin_wr)                  wr_done <= 1'b1;
            else if (stat_wr && wdata[1]) wr_done <= 1'b0;
        end
    end

    assign prefer_wr  = ctrl_q[C_PREF_WR];
    assign be_word    = ctrl_q[C_BE_WORD];
    assign term_empty = ctrl_q[C_TERM];
    assign blen       = ctrl_q[C_BLEN_LO +: BLEN_W];
    assign be_n       = ctrl_q[C_BE_LO +: BE_W];
    assign rd_cmd     = ctrl_q[C_RCMD_LO +: CMD_W];
    assign wr_cmd     = ctrl_q[C_WCMD_LO +: CMD_W];
    assign irq        = ctrl_q[C_IRQ_EN] && (rd_done || wr_done);

    always_comb begin
        case (idx)
            IDX_RADDR: rdata = rd_addr;
            IDX_WADDR: rdata = wr_addr;
            IDX_LEN:   rdata = {wr_len, rd_len};
            IDX_CTRL:  rdata = {ctrl_q, go_wr, go_rd};
            IDX_STAT:  rdata = {{(REG_W-2){1'b0}}, wr_done, rd_done};
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_arb.sv
module dma_arb (
    input  logic pend_rd,
    input  logic pend_wr,
    input  logic prefer_wr,
    output logic pend_any,
    output logic pick_wr
);

    assign pend_any = pend_rd || pend_wr;
    assign pick_wr  = pend_wr && (!pend_rd || prefer_wr);

endmodule

// File: rtl/dma_burst_fsm.sv
module dma_burst_fsm
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_any,
    input  logic              pick_wr,
    input  logic [LEN_W-1:0]  rd_len,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [BLEN_W-1:0] blen,
    input  logic [CMD_W-1:0]  rd_cmd,
    input  logic [CMD_W-1:0]  wr_cmd,
    input  logic [BE_W-1:0]   be_cfg,
    input  logic              be_word_cfg,
    input  logic              term_cfg,
    input  logic              core_wr_ack,
    input  logic              core_rd_valid,
    input  logic              core_wr_done,
    output logic              mreq,
    output logic [CMD_W-1:0]  mcmd,
    output logic [BE_W-1:0]   m_be_n,
    output logic              m_be_per_word,
    output logic              m_rd_term_empty,
    output logic              one_left,
    output logic              two_left,
    output logic              step_rd,
    output logic              step_wr,
    output logic              fin_rd,
    output logic              fin_wr
);

    seq_state_t       state;
    logic             cur_wr;
    logic [LEN_W-1:0] burst_left;
    logic [LEN_W-1:0] sel_len, blen_ext, grant_size;
    logic             phase;

    assign sel_len    = pick_wr ? wr_len : rd_len;
    assign blen_ext   = {{(LEN_W-BLEN_W){1'b0}}, blen};
    assign grant_size = (blen == '0 || sel_len <= blen_ext) ? sel_len : blen_ext;
    assign phase      = cur_wr ? core_wr_ack : core_rd_valid;

    // state register and latched burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= S_IDLE;
            cur_wr          <= 1'b0;
            burst_left      <= '0;
            mcmd            <= '0;
            m_be_n          <= '0;
            m_be_per_word   <= 1'b0;
            m_rd_term_empty <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (pend_any) begin
                        cur_wr          <= pick_wr;
                        burst_left      <= grant_size;
                        mcmd            <= pick_wr ? wr_cmd : rd_cmd;
                        m_be_n          <= be_cfg;
                        m_be_per_word   <= be_word_cfg;
                        m_rd_term_empty <= term_cfg;
                        state           <= S_BURST;
                    end
                end
                S_BURST: begin
                    if (phase) begin
                        burst_left <= burst_left - 1'b1;
                        if (burst_left == LEN_W'(1))
                            state <= S_HOLD;
                    end
                end
                S_HOLD:      state <= cur_wr ? S_WAIT_DONE : S_CLOSE;
                S_WAIT_DONE: if (core_wr_done) state <= S_CLOSE;
                S_CLOSE:     state <= S_IDLE;
                default:     state <= S_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        logic flags_on;
        mreq     = (state == S_BURST) || (state == S_HOLD);
        step_rd  = (state == S_BURST) && !cur_wr && phase;
        step_wr  = (state == S_BURST) &&  cur_wr && phase;
        fin_rd   = (state == S_CLOSE) && !cur_wr && (rd_len == '0);
        fin_wr   = (state == S_CLOSE) &&  cur_wr && (wr_len == '0);
        flags_on = (state == S_BURST) && !cur_wr &&
                   !(m_be_per_word && m_rd_term_empty);
        one_left = flags_on && (burst_left == LEN_W'(1));
        two_left = flags_on && (burst_left == LEN_W'(2));
    end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mreq,
    output logic [CMD_W-1:0]  mcmd,
    output logic [REG_W-1:0]  m_rd_addr,
    output logic [REG_W-1:0]  m_wr_addr,
    output logic [BE_W-1:0]   m_be_n,
    output logic              m_be_per_word,
    output logic              m_rd_term_empty,
    output logic              m_one_left,
    output logic              m_two_left,
    input  logic              core_wr_ack,
    input  logic              core_rd_valid,
    input  logic              core_wr_done,
    output logic              irq
);

    logic              step_rd, step_wr, fin_rd, fin_wr;
    logic [LEN_W-1:0]  rd_len, wr_len;
    logic              go_rd, go_wr, prefer_wr, be_word, term_empty;
    logic [BLEN_W-1:0] blen;
    logic [BE_W-1:0]   be_cfg;
    logic [CMD_W-1:0]  rd_cmd, wr_cmd;
    logic              pend_any, pick_wr;

    dma_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .idx        (reg_idx),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .step_rd    (step_rd),
        .step_wr    (step_wr),
        .fin_rd     (fin_rd),
        .fin_wr     (fin_wr),
        .rd_addr    (m_rd_addr),
        .wr_addr    (m_wr_addr),
        .rd_len     (rd_len),
        .wr_len     (wr_len),
        .go_rd      (go_rd),
        .go_wr      (go_wr),
        .prefer_wr  (prefer_wr),
        .be_word    (be_word),
        .term_empty (term_empty),
        .blen       (blen),
        .be_n       (be_cfg),
        .rd_cmd     (rd_cmd),
        .wr_cmd     (wr_cmd),
        .irq        (irq)
    );

    dma_arb u_arb (
        .pend_rd   (go_rd),
        .pend_wr   (go_wr),
        .prefer_wr (prefer_wr),
        .pend_any  (pend_any),
        .pick_wr   (pick_wr)
    );

    dma_burst_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .pend_any        (pend_any),
        .pick_wr         (pick_wr),
        .rd_len          (rd_len),
        .wr_len          (wr_len),
        .blen            (blen),
        .rd_cmd          (rd_cmd),
        .wr_cmd          (wr_cmd),
        .be_cfg          (be_cfg),
        .be_word_cfg     (be_word),
        .term_cfg        (term_empty),
        .core_wr_ack     (core_wr_ack),
        .core_rd_valid   (core_rd_valid),
        .core_wr_done    (core_wr_done),
        .mreq            (mreq),
        .mcmd            (mcmd),
        .m_be_n          (m_be_n),
        .m_be_per_word   (m_be_per_word),
        .m_rd_term_empty (m_rd_term_empty),
        .one_left        (m_one_left),
        .two_left        (m_two_left),
        .step_rd         (step_rd),
        .step_wr         (step_wr),
        .fin_rd          (fin_rd),
        .fin_wr          (fin_wr)
    );

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [2:0]  reg_idx,
    input logic        mreq,
    input logic [3:0]  mcmd,
    input logic [3:0]  m_be_n,
    input logic [31:0] m_rd_addr,
    input logic [31:0] m_wr_addr,
    input logic        one,
    input logic        two,
    input logic        rd_valid,
    input logic        step_rd,
    input logic        step_wr
);

    // R6: command and byte enables hold while the request stays high
    a_r6_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq && $past(mreq)) |-> ($stable(mcmd) && $stable(m_be_n)));

    // R7: read address steps by four per read phase
    a_r7_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rd && !(reg_we && reg_idx == 3'd0)) |=> (m_rd_addr == $past(m_rd_addr) + 32'd4));

    // R7: write address steps by four per write phase
    a_r7_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_wr && !(reg_we && reg_idx == 3'd1)) |=> (m_wr_addr == $past(m_wr_addr) + 32'd4));

    // R8: the remaining-read flags never overlap
    a_r8_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(one && two));

    // R8: remaining-read flags appear only under an active request
    a_r8_flags_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        (one || two) |-> mreq);

    // R5: request still high the cycle after the last read phase
    a_r5_hold_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (one && rd_valid) |=> mreq);

    // R5: request low in the second cycle after the last read phase
    a_r5_drop_second: assert property (@(posedge clk) disable iff (!rst_n)
        $past(one && rd_valid, 2) |-> !mreq);

endmodule

bind dma_seq dma_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .mreq      (mreq),
    .mcmd      (mcmd),
    .m_be_n    (m_be_n),
    .m_rd_addr (m_rd_addr),
    .m_wr_addr (m_wr_addr),
    .one       (m_one_left),
    .two       (m_two_left),
    .rd_valid  (core_rd_valid),
    .step_rd   (step_rd),
    .step_wr   (step_wr)
);

// File: tb/tb_dma_seq.sv
module tb_dma_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mreq;
    logic [3:0]  mcmd;
    logic [31:0] m_rd_addr, m_wr_addr;
    logic [3:0]  m_be_n;
    logic        m_be_per_word, m_rd_term_empty, m_one_left, m_two_left;
    logic        core_wr_ack = 1'b0;
    logic        core_rd_valid = 1'b0;
    logic        core_wr_done = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] addr;
        logic        one;
        logic        two;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    dma_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mreq(mreq), .mcmd(mcmd),
        .m_rd_addr(m_rd_addr), .m_wr_addr(m_wr_addr), .m_be_n(m_be_n),
        .m_be_per_word(m_be_per_word), .m_rd_term_empty(m_rd_term_empty),
        .m_one_left(m_one_left), .m_two_left(m_two_left),
        .core_wr_ack(core_wr_ack), .core_rd_valid(core_rd_valid),
        .core_wr_done(core_wr_done), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl(input bit go_r, input bit go_w, input bit ien,
                                         input bit pref_w, input bit bew, input bit term,
                                         input logic [7:0] bl, input logic [3:0] be,
                                         input logic [3:0] rc, input logic [3:0] wc);
        return {4'h0, wc, rc, be, bl, 2'b00, term, bew, pref_w, ien, go_w, go_r};
    endfunction

    task automatic reg_write(input logic [2:0] i, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] i, output logic [31:0] d);
        @(negedge clk);
        reg_idx = i;
        #1;
        d = reg_rdata;
    endtask

    // scoreboard monitor: compares each data phase against the queue
    always begin
        @(negedge clk);
        #1;
        if (core_rd_valid || core_wr_ack) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected data phase", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R7 phase address", core_wr_ack ? m_wr_addr : m_rd_addr, e.addr);
                check("R8 one-left flag", {31'd0, m_one_left}, {31'd0, e.one});
                check("R8 two-left flag", {31'd0, m_two_left}, {31'd0, e.two});
            end
        end
    end

    // driver: pushes expectations, then plays the zero-wait core for one burst
    task automatic serve(input bit is_wr, input int n, input logic [31:0] base,
                         input logic [3:0] cmd, input logic [3:0] be,
                         input bit flags_on, input int done_delay);
        int w;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.addr = base + 32'(4 * i);
            e.one  = flags_on && !is_wr && (n - i == 1);
            e.two  = flags_on && !is_wr && (n - i == 2);
            exp_q.push_back(e);
        end
        w = 0;
        @(negedge clk);
        while (!mreq && w < 60) begin
            @(negedge clk);
            w++;
        end
        check("R2 R3 request raised", {31'd0, mreq}, 32'd1);
        check("R6 command at grant", {28'd0, mcmd}, {28'd0, cmd});
        check("R6 byte enables at grant", {28'd0, m_be_n}, {28'd0, be});
        for (int i = 0; i < n; i++) begin
            if (is_wr) core_wr_ack = 1'b1;
            else       core_rd_valid = 1'b1;
            @(negedge clk);
        end
        core_wr_ack = 1'b0;
        core_rd_valid = 1'b0;
        check("R5 request held after last phase", {31'd0, mreq}, 32'd1);
        @(negedge clk);
        check("R5 request low second cycle", {31'd0, mreq}, 32'd0);
        if (is_wr) begin
            for (int d = 0; d < done_delay; d++) begin
                @(negedge clk);
                check("R9 no request before write-done", {31'd0, mreq}, 32'd0);
            end
            core_wr_done = 1'b1;
            @(negedge clk);
            core_wr_done = 1'b0;
        end
    endtask

    task automatic no_request(input string tag, input int cyc);
        int seen;
        seen = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (mreq) seen++;
        end
        check(tag, 32'(seen), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 mreq after reset", {31'd0, mreq}, 32'd0);
        check("R10 irq after reset", {31'd0, irq}, 32'd0);
        for (int i = 0; i < 5; i++) begin
            reg_read(3'(i), v);
            check("R1 register reset value", v, 32'd0);
        end

        // R4 R7 R8 unlimited read of three words
        reg_write(3'd0, 32'h0000_1000);
        reg_write(3'd2, {16'd0, 16'd3});
        reg_write(3'd3, ctrl(1, 0, 1, 0, 0, 0, 8'd0, 4'h0, 4'h6, 4'h7));
        serve(0, 3, 32'h1000, 4'h6, 4'h0, 1, 0);
        reg_read(3'd4, v); check("R10 read done bit", v, 32'h1);
        check("R10 irq raised", {31'd0, irq}, 32'd1);
        reg_read(3'd0, v); check("R7 read address advanced", v, 32'h0000_100C);
        reg_read(3'd2, v); check("R7 read length consumed", v, 32'd0);
        reg_read(3'd3, v); check("R2 start bit cleared on completion", {31'd0, v[0]}, 32'd0);
        reg_write(3'd4, 32'h1);
        check("R10 irq cleared by W1C", {31'd0, irq}, 32'd0);
        reg_read(3'd4, v); check("R10 status cleared", v, 32'd0);

        // R8 single-phase read, irq disabled, fixed byte enables
        reg_write(3'd2, {16'd0, 16'd1});
        reg_write(3'd3, ctrl(1, 0, 0, 0, 0, 0, 8'd0, 4'h3, 4'hC, 4'h7));
        serve(0, 1, 32'h100C, 4'hC, 4'h3, 1, 0);
        reg_read(3'd4, v); check("R10 done set with irq off", v, 32'h1);
        check("R10 irq masked", {31'd0, irq}, 32'd0);
        reg_write(3'd4, 32'h1);

        // R4 R9 write of five words in bursts of two
        reg_write(3'd1, 32'h0000_2000);
        reg_write(3'd2, {16'd5, 16'd0});
        reg_write(3'd3, ctrl(0, 1, 1, 0, 0, 0, 8'd2, 4'hA, 4'h6, 4'h7));
        serve(1, 2, 32'h2000, 4'h7, 4'hA, 0, 3);
        reg_read(3'd4, v); check("R9 not retired between bursts", v, 32'd0);
        serve(1, 2, 32'h2008, 4'h7, 4'hA, 0, 1);
        serve(1, 1, 32'h2010, 4'h7, 4'hA, 0, 0);
        reg_read(3'd4, v); check("R10 write done bit", v, 32'h2);
        check("R10 irq from write", {31'd0, irq}, 32'd1);
        reg_read(3'd1, v); check("R7 write address advanced", v, 32'h0000_2014);
        reg_write(3'd4, 32'h2);

        // R3 both pending, read preferred
        reg_write(3'd0, 32'h0000_3000);
        reg_write(3'd1, 32'h0000_4000);
        reg_write(3'd2, {16'd1, 16'd2});
        reg_write(3'd3, ctrl(1, 1, 0, 0, 0, 0, 8'd0, 4'h0, 4'h6, 4'h7));
        serve(0, 2, 32'h3000, 4'h6, 4'h0, 1, 0);
        serve(1, 1, 32'h4000, 4'h7, 4'h0, 0, 0);
        repeat (2) @(negedge clk);
        reg_read(3'd4, v); check("R3 both channels done", v, 32'h3);
        reg_write(3'd4, 32'h3);

        // R3 both pending, write preferred
        reg_write(3'd0, 32'h0000_5000);
        reg_write(3'd1, 32'h0000_6000);
        reg_write(3'd2, {16'd2, 16'd1});
        reg_write(3'd3, ctrl(1, 1, 0, 1, 0, 0, 8'd0, 4'h0, 4'hE, 4'hF));
        serve(1, 2, 32'h6000, 4'hF, 4'h0, 0, 0);
        serve(0, 1, 32'h5000, 4'hE, 4'h0, 1, 0);
        repeat (2) @(negedge clk);
        reg_write(3'd4, 32'h3);

        // R8 R11 termination on empty suppresses flags
        reg_write(3'd0, 32'h0000_7000);
        reg_write(3'd2, {16'd0, 16'd3});
        reg_write(3'd3, ctrl(1, 0, 0, 0, 1, 1, 8'd0, 4'h0, 4'h6, 4'h7));
        serve(0, 3, 32'h7000, 4'h6, 4'h0, 0, 0);
        check("R11 per-word select latched", {31'd0, m_be_per_word}, 32'd1);
        check("R11 term-on-empty latched", {31'd0, m_rd_term_empty}, 32'd1);
        repeat (2) @(negedge clk);
        reg_write(3'd4, 32'h1);

        // R2 refused starts
        reg_write(3'd3, ctrl(1, 0, 0, 0, 0, 0, 8'd0, 4'h0, 4'h6, 4'h7));
        no_request("R2 zero length refused", 8);
        reg_read(3'd3, v); check("R2 start bit stays clear (zero length)", {31'd0, v[0]}, 32'd0);
        reg_write(3'd2, {16'd1, 16'd2});
        reg_write(3'd3, ctrl(1, 0, 0, 0, 0, 0, 8'd0, 4'h0, 4'h7, 4'h7));
        no_request("R2 write-class command on read refused", 8);
        reg_read(3'd3, v); check("R2 read start bit stays clear", {31'd0, v[0]}, 32'd0);
        reg_write(3'd3, ctrl(0, 1, 0, 0, 0, 0, 8'd0, 4'h0, 4'h6, 4'h6));
        no_request("R2 read-class command on write refused", 8);
        reg_read(3'd3, v); check("R2 write start bit stays clear", {31'd0, v[1]}, 32'd0);

        check("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule